// File: doc/BRIEF.md
# 1-Wire ROM Command and Device Selection Layer

This block is the network layer of a 1-Wire slave. It sits between a bit-level slot engine, which times resets and read/write slots on the wire, and a function layer, which handles the device's own commands. After every bus reset it takes in one 8-bit ROM command, least significant bit first. It then decides whether this device is addressed. If it is, `funcActive` rises and the function layer takes over until the next bus reset. If it is not, the block stays quiet until that reset.

The 64-bit registration number is the family code in the low byte, then a 48-bit serial number, then a CRC-8 in the top byte. The family code and serial are parameters. The CRC is worked out by a serial LFSR in the 56 cycles that follow the block's own reset. The block supports read, match, skip, search, conditional search, overdrive skip, overdrive match and resume. The conditional search is gated by an input that reports whether the wiper sits at its default position. An overdrive request goes back to the slot engine.

The slot interface is one strobe per slot. Before a slot, the slot engine samples `txBit`: 0 means pull the line low and 1 means release it. At the strobe, the engine supplies `rxBit`, which is the line level it sampled, the wired-AND of master and slave.

Top module: `onew_rom_layer`

## Requirements
- R1: While `rstN` is low and in the cycles after it, `txBit`=1, `overdrive`=0 and `funcActive`=0. Slots that arrive after start-up but before the first bus reset have no effect.
- R2: Command 33h returns the 64-bit number on `txBit` over 64 slots, bit 0 first. Bits 7:0 are the family code, bits 55:8 are the serial, and bits 63:56 are the CRC-8 of bits 55:0 (polynomial x^8+x^5+x^4+1, register starting at zero, data fed LSB first). `funcActive` rises after the 64th slot.
- R3: Command 55h compares 64 received bits against the number. A full match raises `funcActive`. Any mismatch deselects the device at once, and `txBit` stays 1 until the next bus reset.
- R4: Command CCh raises `funcActive` one cycle after the 8th command slot and clears the resume flag.
- R5: Command F0h runs 64 triplets. In each triplet the device sends its bit, then sends the complement of that bit, then reads the master's bit. The device drops out (`txBit`=1 from then on) when the master's bit differs from its own. If it survives all 64 triplets it is selected.
- R6: Command ECh behaves like F0h when `condMet`=1 at the 8th command slot. Otherwise the device takes no part: it sends 1 in every slot, is not selected, and its resume flag clears.
- R7: Command 3Ch sets `overdrive` one cycle after the 8th command slot and selects the device.
- R8: Command 69h sets `overdrive` right after the command byte and then matches 64 bits. A full match selects the device and keeps `overdrive`. A mismatch puts `overdrive` back to the value it had before the command.
- R9: A bus reset with `longRst`=1 clears `overdrive` by the next cycle. A bus reset with `longRst`=0 leaves it unchanged.
- R10: Command A5h selects the device only if the resume flag is set. The flag is set by a successful 55h, F0h, ECh or 69h. It is cleared by a lost match or search, a non-participating ECh, CCh and 3Ch. Commands 33h and unknown codes leave it unchanged.
- R11: Any other command code deselects the device, which keeps `txBit`=1 until the next bus reset.
- R12: A bus reset at any point drops `funcActive` by the next cycle and restarts command reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the block (power-on) |
| busRst | input | 1 | One-cycle pulse: a reset pulse was seen on the wire |
| longRst | input | 1 | Qualifies `busRst`: the reset pulse was long enough to leave overdrive |
| slotStb | input | 1 | One-cycle pulse at the end of each read/write slot |
| rxBit | input | 1 | Line level sampled in the slot that `slotStb` ends |
| condMet | input | 1 | 1 when the device state meets the conditional-search condition |
| txBit | output | 1 | Bit for the next slot: 0 pulls the line low, 1 releases it |
| overdrive | output | 1 | Request to the slot engine to use overdrive timing |
| funcActive | output | 1 | Device is selected; the function layer owns the bus |

## Verification
Every state change lands on the clock edge that carries `slotStb` or `busRst`. So `funcActive`, `overdrive` and the resume outcome are due one cycle after the strobe. `txBit` follows the state with no further register, so it is already valid for the next slot before that slot's strobe. The bench drives each strobe for one cycle starting at a falling edge. It reads `txBit` at that falling edge, before the strobe, and reads the registered outputs at the following falling edge. The CRC is ready 56 cycles after `rstN` rises, and the bench waits longer than that before its first bus reset.

// File: rtl/onew_rom_pkg.sv
package onew_rom_pkg;
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int PRE_W = FAM_W + SER_W;
  localparam int ROM_W = PRE_W + CRC_W;
  localparam int IDX_W = $clog2(ROM_W);
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ    = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH   = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SEARCH  = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_CSEARCH = 8'hEC;
  localparam logic [CMD_W-1:0] CMD_SKIP    = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_ODSKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] CMD_ODMATCH = 8'h69;
  localparam logic [CMD_W-1:0] CMD_RESUME  = 8'hA5;

  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_BIT,
    ST_SRCH_CMP,
    ST_SRCH_SEL,
    ST_SEL
  } romState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic cmdShift;
  } dpStrobe_t;
endpackage

// File: rtl/onew_rom_datapath.sv
module onew_rom_datapath
  import onew_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2C,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h00A5_3C96_17E2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        ctl,
  input  logic             rxBit,
  output logic             romBit,
  output logic [IDX_W-1:0] bitIdx,
  output logic [CMD_W-1:0] cmdNext,
  output logic             crcDone
);
  localparam logic [PRE_W-1:0] PRE_VEC  = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [IDX_W-1:0] CRC_LAST = IDX_W'(PRE_W - 1);

  logic [CRC_W-1:0] crcReg;
  logic [IDX_W-1:0] crcCnt;
  logic [CMD_W-1:0] cmdReg;
  logic [ROM_W-1:0] romVec;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur, input logic din);
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = cur[0] ^ din;
    nxt = cur >> 1;
    if (fb) nxt = nxt ^ CRC_POLY_REFL;
    return nxt;
  endfunction

  // Serial CRC over family code and serial, once after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg  <= '0;
      crcCnt  <= '0;
      crcDone <= 1'b0;
    end else if (!crcDone) begin
      crcReg <= crcStep(crcReg, PRE_VEC[crcCnt]);
      if (crcCnt == CRC_LAST) crcDone <= 1'b1;
      else crcCnt <= crcCnt + 1'b1;
    end
  end

  // Shared bit index for command bits and ROM bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitIdx <= '0;
    else if (ctl.cntClr) bitIdx <= '0;
    else if (ctl.cntInc) bitIdx <= bitIdx + 1'b1;
  end

  assign cmdNext = {rxBit, cmdReg[CMD_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdReg <= '0;
    else if (ctl.cmdShift) cmdReg <= cmdNext;
  end

  assign romVec = {crcReg, SERIAL_NUM, FAMILY_CODE};
  assign romBit = romVec[bitIdx];

  p_crc_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    crcDone |=> $stable(crcReg));
  p_clr_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClr |=> (bitIdx == '0));
endmodule

// File: rtl/onew_rom_control.sv
module onew_rom_control
  import onew_rom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busRst,
  input  logic             longRst,
  input  logic             slotStb,
  input  logic             rxBit,
  input  logic             condMet,
  input  logic             romBit,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic             crcDone,
  output dpStrobe_t        ctl,
  output logic             txBit,
  output logic             overdrive,
  output logic             funcActive
);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

  romState_e state, stNext;
  logic resumeFlag, rcNext;
  logic odNext, odBefore, odbNext;
  logic romLast;

  assign romLast = &bitIdx;

  always_comb begin
    stNext  = state;
    rcNext  = resumeFlag;
    odNext  = overdrive;
    odbNext = odBefore;
    ctl     = '0;
    if (state == ST_INIT) begin
      if (crcDone) stNext = ST_IDLE;
    end else if (busRst) begin
      stNext     = ST_CMD;
      ctl.cntClr = 1'b1;
      if (longRst) odNext = 1'b0;
    end else if (slotStb) begin
      unique case (state)
        ST_CMD: begin
          ctl.cmdShift = 1'b1;
          ctl.cntInc   = 1'b1;
          if (bitIdx == CMD_LAST) begin
            ctl.cntClr = 1'b1;
            case (cmdNext)
              CMD_READ:    stNext = ST_READ;
              CMD_MATCH: begin
                stNext  = ST_MATCH;
                odbNext = overdrive;
              end
              CMD_SEARCH:  stNext = ST_SRCH_BIT;
              CMD_CSEARCH: begin
                if (condMet) stNext = ST_SRCH_BIT;
                else begin
                  stNext = ST_IDLE;
                  rcNext = 1'b0;
                end
              end
              CMD_SKIP: begin
                stNext = ST_SEL;
                rcNext = 1'b0;
              end
              CMD_ODSKIP: begin
                stNext = ST_SEL;
                rcNext = 1'b0;
                odNext = 1'b1;
              end
              CMD_ODMATCH: begin
                stNext  = ST_MATCH;
                odbNext = overdrive;
                odNext  = 1'b1;
              end
              CMD_RESUME:  stNext = resumeFlag ? ST_SEL : ST_IDLE;
              default:     stNext = ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          ctl.cntInc = 1'b1;
          if (romLast) stNext = ST_SEL;
        end
        ST_MATCH: begin
          if (rxBit != romBit) begin
            stNext = ST_IDLE;
            rcNext = 1'b0;
            odNext = odBefore;
          end else if (romLast) begin
            stNext = ST_SEL;
            rcNext = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_SRCH_BIT: stNext = ST_SRCH_CMP;
        ST_SRCH_CMP: stNext = ST_SRCH_SEL;
        ST_SRCH_SEL: begin
          if (rxBit != romBit) begin
            stNext = ST_IDLE;
            rcNext = 1'b0;
          end else if (romLast) begin
            stNext = ST_SEL;
            rcNext = 1'b1;
          end else begin
            stNext     = ST_SRCH_BIT;
            ctl.cntInc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_INIT;
      resumeFlag <= 1'b0;
      overdrive  <= 1'b0;
      odBefore   <= 1'b0;
    end else begin
      state      <= stNext;
      resumeFlag <= rcNext;
      overdrive  <= odNext;
      odBefore   <= odbNext;
    end
  end

  always_comb begin
    unique case (state)
      ST_READ, ST_SRCH_BIT: txBit = romBit;
      ST_SRCH_CMP:          txBit = ~romBit;
      default:              txBit = 1'b1;
    endcase
  end

  assign funcActive = (state == ST_SEL);

  p_long_reset_od_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRst && longRst && state != ST_INIT) |=> !overdrive);
  p_reset_deselects_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busRst && state != ST_INIT) |=> !funcActive);
  p_cmd_index_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD) |-> (bitIdx < IDX_W'(CMD_W)));
  p_resume_after_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumeFlag) |-> $past(slotStb));
  p_od_from_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overdrive) |-> ($past(state) == ST_CMD));
  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !crcDone |-> (txBit && !funcActive));
endmodule

// File: rtl/onew_rom_layer.sv
module onew_rom_layer
  import onew_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2C,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h00A5_3C96_17E2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busRst,
  input  logic longRst,
  input  logic slotStb,
  input  logic rxBit,
  input  logic condMet,
  output logic txBit,
  output logic overdrive,
  output logic funcActive
);
  dpStrobe_t        ctl;
  logic             romBit;
  logic [IDX_W-1:0] bitIdx;
  logic [CMD_W-1:0] cmdNext;
  logic             crcDone;

  onew_rom_datapath #(
    .FAMILY_CODE(FAMILY_CODE),
    .SERIAL_NUM (SERIAL_NUM)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rxBit  (rxBit),
    .romBit (romBit),
    .bitIdx (bitIdx),
    .cmdNext(cmdNext),
    .crcDone(crcDone)
  );

  onew_rom_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busRst    (busRst),
    .longRst   (longRst),
    .slotStb   (slotStb),
    .rxBit     (rxBit),
    .condMet   (condMet),
    .romBit    (romBit),
    .bitIdx    (bitIdx),
    .cmdNext   (cmdNext),
    .crcDone   (crcDone),
    .ctl       (ctl),
    .txBit     (txBit),
    .overdrive (overdrive),
    .funcActive(funcActive)
  );
endmodule

// File: tb/sim_onew_rom_layer.sv
module sim_onew_rom_layer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  FAM = 8'h2C;
  localparam logic [47:0] SER = 48'h1F83_6C04_D2B9;

  logic clk = 1'b0;
  logic rstN, busRst, longRst, slotStb, rxBit, condMet;
  logic txBit, overdrive, funcActive;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] expRom;

  onew_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u0 (
    .clk(clk), .rstN(rstN), .busRst(busRst), .longRst(longRst),
    .slotStb(slotStb), .rxBit(rxBit), .condMet(condMet),
    .txBit(txBit), .overdrive(overdrive), .funcActive(funcActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] crcOf(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = c[0] ^ v[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic m, output logic seen);
    @(negedge clk);
    seen = txBit;
    rxBit = m & txBit;
    slotStb = 1'b1;
    @(negedge clk);
    slotStb = 1'b0;
    rxBit = 1'b1;
  endtask

  task automatic doReset(input logic isLong);
    @(negedge clk);
    busRst = 1'b1;
    longRst = isLong;
    @(negedge clk);
    busRst = 1'b0;
    longRst = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic d;
    for (int i = 0; i < 8; i++) slot(b[i], d);
  endtask

  task automatic readRom(output logic [63:0] v);
    for (int i = 0; i < 64; i++) slot(1'b1, v[i]);
  endtask

  task automatic sendBits(input logic [63:0] v);
    logic d;
    for (int i = 0; i < 64; i++) slot(v[i], d);
  endtask

  // Search triplets; checks what this device drives while it is still in
  task automatic searchRun(input string req, input logic [63:0] path, input logic takesPart);
    logic alive, a, b, d;
    alive = takesPart;
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, a);
      slot(1'b1, b);
      check(req, {62'd0, a, b}, alive ? {62'd0, expRom[i], ~expRom[i]} : 64'd3);
      slot(path[i], d);
      if (path[i] != expRom[i]) alive = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [63:0] got;
    logic d;
    logic expSel, expRc, expOd, odb;
    void'($urandom(32'h00C0FFEE));
    expRom = {crcOf({8'h00, SER, FAM}, 56), SER, FAM};
    rstN = 1'b0; busRst = 1'b0; longRst = 1'b0; slotStb = 1'b0; rxBit = 1'b1; condMet = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {61'd0, txBit, overdrive, funcActive}, 64'd4);
    rstN = 1'b1;
    repeat (70) @(negedge clk);
    // R1: slots before the first bus reset are ignored
    sendByte(8'hCC);
    check("R1 no select before bus reset", {63'd0, funcActive}, 64'd0);

    // R2 read
    doReset(1'b1);
    sendByte(8'h33);
    readRom(got);
    check("R2 read number", got, expRom);
    check("R2 crc residue zero", {56'd0, crcOf(got, 64)}, 64'd0);
    check("R2 selected after read", {63'd0, funcActive}, 64'd1);

    // R12 reset while selected and mid-read
    doReset(1'b1);
    check("R12 reset deselects", {63'd0, funcActive}, 64'd0);
    sendByte(8'h33);
    for (int i = 0; i < 10; i++) slot(1'b1, d);
    doReset(1'b1);
    sendByte(8'hCC);
    check("R12 command restarts after reset", {63'd0, funcActive}, 64'd1);

    // R5 search win then R10 resume
    doReset(1'b1);
    sendByte(8'hF0);
    searchRun("R5 search triplet", expRom, 1'b1);
    check("R5 search winner selected", {63'd0, funcActive}, 64'd1);
    doReset(1'b1);
    sendByte(8'hA5);
    check("R10 resume after search", {63'd0, funcActive}, 64'd1);

    // R4 skip clears resume flag
    doReset(1'b1);
    sendByte(8'hCC);
    check("R4 skip selects", {63'd0, funcActive}, 64'd1);
    doReset(1'b1);
    sendByte(8'hA5);
    check("R4 R10 resume refused after skip", {63'd0, funcActive}, 64'd0);

    // R3 match mismatch, then exact
    doReset(1'b1);
    sendByte(8'h55);
    sendBits(expRom ^ (64'd1 << 40));
    slot(1'b1, d);
    check("R3 mismatch releases line", {63'd0, d}, 64'd1);
    check("R3 mismatch not selected", {63'd0, funcActive}, 64'd0);
    doReset(1'b1);
    sendByte(8'h55);
    sendBits(expRom);
    check("R3 full match selects", {63'd0, funcActive}, 64'd1);

    // R6 conditional search
    condMet = 1'b0;
    doReset(1'b1);
    sendByte(8'hEC);
    slot(1'b1, d);
    check("R6 no part when condition false", {62'd0, d, funcActive}, 64'd2);
    doReset(1'b1);
    sendByte(8'hA5);
    check("R6 R10 resume cleared by skipped cond search", {63'd0, funcActive}, 64'd0);
    condMet = 1'b1;
    doReset(1'b1);
    sendByte(8'hEC);
    searchRun("R6 cond search triplet", expRom, 1'b1);
    check("R6 cond search selects", {63'd0, funcActive}, 64'd1);

    // R7, R9, R8 overdrive
    doReset(1'b1);
    sendByte(8'h3C);
    check("R7 overdrive skip", {62'd0, overdrive, funcActive}, 64'd3);
    doReset(1'b0);
    check("R9 short reset keeps overdrive", {63'd0, overdrive}, 64'd1);
    doReset(1'b1);
    check("R9 long reset clears overdrive", {63'd0, overdrive}, 64'd0);
    doReset(1'b1);
    sendByte(8'h69);
    check("R8 overdrive on after command", {63'd0, overdrive}, 64'd1);
    sendBits(expRom ^ 64'd1);
    check("R8 mismatch restores speed", {62'd0, overdrive, funcActive}, 64'd0);
    doReset(1'b1);
    sendByte(8'h69);
    sendBits(expRom);
    check("R8 od match selects", {62'd0, overdrive, funcActive}, 64'd3);
    doReset(1'b0);
    sendByte(8'hA5);
    check("R10 resume in overdrive", {62'd0, overdrive, funcActive}, 64'd3);

    // R11 unknown code
    doReset(1'b1);
    sendByte(8'h12);
    slot(1'b1, d);
    check("R11 unknown code ignored", {62'd0, d, funcActive}, 64'd2);

    // R5 search loss
    doReset(1'b1);
    sendByte(8'hF0);
    searchRun("R5 search loser triplet", expRom ^ (64'd1 << 20), 1'b1);
    check("R5 search loser released", {63'd0, funcActive}, 64'd0);
    doReset(1'b1);
    sendByte(8'hA5);
    check("R5 R10 resume refused after loss", {63'd0, funcActive}, 64'd0);

    // Random command mix against a bench model
    expRc = 1'b0; expOd = 1'b0;
    for (int it = 0; it < 60; it++) begin
      logic [7:0] codes [9];
      logic [7:0] cmd;
      logic isLong, flip, cm;
      int pos;
      codes = '{8'h33, 8'h55, 8'hF0, 8'hEC, 8'hCC, 8'h3C, 8'h69, 8'hA5, 8'h5A};
      cmd = codes[$urandom % 9];
      isLong = 1'($urandom % 2);
      doReset(isLong);
      if (isLong) expOd = 1'b0;
      cm = 1'($urandom % 2);
      condMet = cm;
      sendByte(cmd);
      expSel = 1'b0;
      case (cmd)
        8'h33: begin
          readRom(got);
          check("R2 random read", got, expRom);
          expSel = 1'b1;
        end
        8'h55, 8'h69: begin
          flip = 1'($urandom % 2);
          pos = int'($urandom % 64);
          odb = expOd;
          if (cmd == 8'h69) begin
            expOd = 1'b1;
            check("R8 random od on", {63'd0, overdrive}, 64'd1);
          end
          sendBits(flip ? expRom ^ (64'd1 << pos) : expRom);
          if (flip) begin expRc = 1'b0; expOd = odb; end
          else begin expRc = 1'b1; expSel = 1'b1; end
        end
        8'hF0, 8'hEC: begin
          logic part;
          pos = int'($urandom % 80);
          part = (cmd == 8'hF0) ? 1'b1 : cm;
          searchRun("R5 R6 random search", (pos < 64) ? expRom ^ (64'd1 << pos) : expRom, part);
          if (part && pos >= 64) begin expSel = 1'b1; expRc = 1'b1; end
          else expRc = 1'b0;
        end
        8'hCC: begin expSel = 1'b1; expRc = 1'b0; end
        8'h3C: begin expSel = 1'b1; expRc = 1'b0; expOd = 1'b1; end
        8'hA5: expSel = expRc;
        default: expSel = 1'b0;
      endcase
      check("R10 R12 random selection", {63'd0, funcActive}, {63'd0, expSel});
      check("R9 random overdrive", {63'd0, overdrive}, {63'd0, expOd});
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule